// File: doc/BRIEF.md
# Timer Output Compare Unit

This block sits beside an 8-bit timer/counter and produces one compare channel. The counter, its prescaler and any interrupt logic are outside it. The counter value, a one-cycle tick enable, top and bottom indications and the waveform mode come in as inputs. The block keeps a compare value and tests it against the counter on every tick. On an equal, unblocked tick it raises a sticky match flag and emits a one-cycle match pulse, which the counter can use to restart in clear-on-match mode. It also updates an internal output-compare bit according to a 2-bit action field.

In the two PWM waveform modes, software writes go to a holding register. The active compare value is copied from that register only at one end of the count: the top in one PWM mode, the bottom in the other. This keeps pulse widths whole. In the normal and clear-on-match modes, writes reach the active value directly.

A force strobe applies the configured action to the output bit without touching the flag or the match pulse. It works only outside PWM. Any software write to the counter masks compare matches on the next tick, however many cycles pass before that tick arrives. The output pin follows the output-compare bit while the action field is nonzero and follows the port latch otherwise.

Top module: `cmp_unit`

## Requirements
- R1: After reset the match flag, the match pulse, the output-compare bit and the active compare value are all 0.
- R2: With `wave_mode` 0 (normal) or 1 (clear-on-match), a compare write (`cmp_wr`) sets `cmp_active` to the written value one cycle later.
- R3: With `wave_mode` 2, a compare write changes only the holding register, which is copied to `cmp_active` on a tick with `at_top` high. With `wave_mode` 3, the copy happens on a tick with `at_bottom` high. On any other cycle `cmp_active` keeps its value.
- R4: A tick on which `count` equals `cmp_active` and matches are not blocked sets `match_flag` and raises `match_pulse` for exactly one cycle. Both outputs change one cycle after that tick.
- R5: A `flag_clr` high for one cycle clears `match_flag`. When a match and a clear fall in the same cycle, the flag ends up set.
- R6: On a match, `act_sel` selects the change to the output-compare bit: 00 leaves it unchanged, 01 inverts it, 10 clears it and 11 sets it.
- R7: In modes 0 and 1, `force_cmp` applies the R6 action to the output-compare bit one cycle later. It does not set `match_flag` and does not raise `match_pulse`.
- R8: In modes 2 and 3, `force_cmp` has no effect on the output-compare bit.
- R9: A `cnt_wr` pulse masks the compare on the next tick that follows it, even when many cycles without a tick pass in between. The tick after that one compares normally.
- R10: `pin_out` equals `oc_bit` when `act_sel` is nonzero and equals `port_latch` when `act_sel` is 00. The selection follows `act_sel` in the same cycle, without a register.
- R11: The output-compare bit keeps its value when `wave_mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per count step |
| count | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at its top value |
| at_bottom | input | 1 | Counter is at zero |
| wave_mode | input | 2 | 0 normal, 1 clear-on-match, 2 PWM updated at top, 3 PWM updated at bottom |
| act_sel | input | 2 | Output action on match or force (see R6) |
| cmp_wr | input | 1 | Software write strobe for the compare value |
| cmp_wdata | input | 8 | Compare value being written |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| force_cmp | input | 1 | Self-clearing force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| port_latch | input | 1 | General-purpose port value for the pin |
| cmp_active | output | 8 | Compare value in use |
| match_flag | output | 1 | Sticky match flag |
| match_pulse | output | 1 | One-cycle match event, for clearing the counter |
| oc_bit | output | 1 | Output-compare bit |
| pin_out | output | 1 | Pin value after the port/compare selection |

## Verification
The compare value, the flag, the match pulse and the output-compare bit all sit one register away from their stimulus. The pin selection has no register at all. The bench changes inputs on the falling edge and lets one rising edge go by. It then samples one time unit after the next falling edge, so registered results are read in the cycle after their cause and `pin_out` is read in the cycle its select changed. A behavioural model advanced on every rising edge predicts all five outputs. The bench compares them against the model every cycle. Directed checks at the same sampling point cover the PWM load points, the blocking window across idle cycles and a flag clear that meets a match.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [1:0] {
        WG_NORMAL   = 2'd0,
        WG_CLRMATCH = 2'd1,
        WG_PWM_TOP  = 2'd2,
        WG_PWM_BOT  = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_TOG  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_SET  = 2'd3
    } act_e;

    function automatic logic is_pwm(wave_e m);
        return (m == WG_PWM_TOP) || (m == WG_PWM_BOT);
    endfunction

endpackage

// File: rtl/cmp_store.sv
module cmp_store
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wave_e        mode,
    input  logic         tick,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] active
);

    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } st_t;

    st_t s_d, s_q;
    logic pwm, edge_pt;

    always_comb begin
        pwm     = is_pwm(mode);
        edge_pt = (mode == WG_PWM_TOP) ? at_top : at_bottom;
        s_d     = s_q;
        if (wr)
            s_d.hold = wdata;
        if (!pwm && wr)
            s_d.act = wdata;
        else if (pwm && tick && edge_pt)
            s_d.act = s_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign active = s_q.act;

    // R2
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pwm(mode) && wr) |=> (active == $past(wdata)));

    // R3
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(mode) && !tick) |=> $stable(active));

endmodule

// File: rtl/cmp_detect.sv
module cmp_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] active,
    input  logic         cnt_wr,
    input  logic         flag_clr,
    output logic         match_evt,
    output logic         flag,
    output logic         hit
);

    typedef struct packed {
        logic blk;
        logic flag;
        logic hit;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        match_evt = tick && (count == active) && !s_q.blk;
        s_d       = s_q;
        if (cnt_wr)
            s_d.blk = 1'b1;
        else if (tick)
            s_d.blk = 1'b0;
        if (match_evt)
            s_d.flag = 1'b1;
        else if (flag_clr)
            s_d.flag = 1'b0;
        s_d.hit = match_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign flag = s_q.flag;
    assign hit  = s_q.hit;

    // R9
    blocked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.blk && tick) |=> !hit);

    // R4
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> flag);

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !tick) |=> !hit);

endmodule

// File: rtl/cmp_wave.sv
module cmp_wave
    import cmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  wave_e mode,
    input  act_e  act,
    input  logic  match_evt,
    input  logic  force_cmp,
    input  logic  port_latch,
    output logic  oc,
    output logic  pin
);

    typedef struct packed {
        logic oc;
    } st_t;

    st_t s_d, s_q;
    logic fire;

    always_comb begin
        fire = match_evt || (force_cmp && !is_pwm(mode));
        s_d  = s_q;
        if (fire) begin
            case (act)
                ACT_TOG:  s_d.oc = !s_q.oc;
                ACT_CLR:  s_d.oc = 1'b0;
                ACT_SET:  s_d.oc = 1'b1;
                default:  s_d.oc = s_q.oc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign oc  = s_q.oc;
    assign pin = (act == ACT_HOLD) ? port_latch : s_q.oc;

    // R8
    pwm_force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm(mode) && !match_evt) |=> $stable(oc));

    // R6
    set_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && act == ACT_SET) |=> oc);

    // R6
    hold_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> $stable(oc));

endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   act_sel,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cnt_wr,
    input  logic         force_cmp,
    input  logic         flag_clr,
    input  logic         port_latch,
    output logic [W-1:0] cmp_active,
    output logic         match_flag,
    output logic         match_pulse,
    output logic         oc_bit,
    output logic         pin_out
);

    wave_e mode;
    act_e  act;
    logic  match_evt;

    assign mode = wave_e'(wave_mode);
    assign act  = act_e'(act_sel);

    cmp_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .tick      (tick),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .wr        (cmp_wr),
        .wdata     (cmp_wdata),
        .active    (cmp_active)
    );

    cmp_detect #(.W(W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .count     (count),
        .active    (cmp_active),
        .cnt_wr    (cnt_wr),
        .flag_clr  (flag_clr),
        .match_evt (match_evt),
        .flag      (match_flag),
        .hit       (match_pulse)
    );

    cmp_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .act        (act),
        .match_evt  (match_evt),
        .force_cmp  (force_cmp),
        .port_latch (port_latch),
        .oc         (oc_bit),
        .pin        (pin_out)
    );

    // R7
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick && !match_flag) |=> (!match_flag && !match_pulse));

endmodule

// File: tb/cmp_unit_test.sv
module cmp_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] count = '0;
    logic       at_top = 1'b0;
    logic       at_bottom = 1'b0;
    logic [1:0] wave_mode = 2'd0;
    logic [1:0] act_sel = 2'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       cnt_wr = 1'b0;
    logic       force_cmp = 1'b0;
    logic       flag_clr = 1'b0;
    logic       port_latch = 1'b0;
    logic [7:0] cmp_active;
    logic       match_flag, match_pulse, oc_bit, pin_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;

    cmp_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .at_top(at_top), .at_bottom(at_bottom), .wave_mode(wave_mode),
        .act_sel(act_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cnt_wr(cnt_wr), .force_cmp(force_cmp), .flag_clr(flag_clr),
        .port_latch(port_latch), .cmp_active(cmp_active),
        .match_flag(match_flag), .match_pulse(match_pulse),
        .oc_bit(oc_bit), .pin_out(pin_out)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    int m_hold = 0, m_act = 0, m_blk = 0, m_flag = 0, m_hit = 0, m_oc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold = 0; m_act = 0; m_blk = 0; m_flag = 0; m_hit = 0; m_oc = 0;
        end else begin
            int  n_act, n_oc;
            bit  pwm, ev, doit;
            pwm   = (wave_mode >= 2);
            ev    = tick && (int'(count) == m_act) && (m_blk == 0);
            n_act = m_act;
            if (!pwm && cmp_wr) n_act = cmp_wdata;
            else if (tick && wave_mode == 2 && at_top) n_act = m_hold;
            else if (tick && wave_mode == 3 && at_bottom) n_act = m_hold;
            if (cmp_wr) m_hold = cmp_wdata;
            m_act = n_act;
            if (cnt_wr) m_blk = 1; else if (tick) m_blk = 0;
            if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
            m_hit = ev ? 1 : 0;
            doit  = ev || (force_cmp && !pwm);
            n_oc  = m_oc;
            if (doit) begin
                if (act_sel == 2'd1) n_oc = 1 - m_oc;
                else if (act_sel == 2'd2) n_oc = 0;
                else if (act_sel == 2'd3) n_oc = 1;
            end
            m_oc = n_oc;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2/R3", "model cmp_active", cmp_active, m_act);
            chk("R4/R5", "model match_flag", match_flag, m_flag);
            chk("R4",    "model match_pulse", match_pulse, m_hit);
            chk("R6/R7", "model oc_bit", oc_bit, m_oc);
            chk("R10",   "model pin_out", pin_out,
                (act_sel != 0) ? m_oc : int'(port_latch));
        end
    end

    // release strobes one edge after they were applied, then sample
    task automatic settle();
        @(negedge clk);
        tick = 0; cmp_wr = 0; cnt_wr = 0; force_cmp = 0; flag_clr = 0;
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "cmp_active", cmp_active, 0);
        chk("R1", "match_flag", match_flag, 0);
        chk("R1", "match_pulse", match_pulse, 0);
        chk("R1", "oc_bit", oc_bit, 0);

        // R2 direct write in normal mode
        @(negedge clk); cmp_wr = 1; cmp_wdata = 8'h40;
        settle();
        chk("R2", "cmp_active normal", cmp_active, 8'h40);

        // R4 R6 toggle on match
        @(negedge clk); act_sel = 2'd1; count = 8'h40; tick = 1;
        settle();
        chk("R4", "match_flag", match_flag, 1);
        chk("R4", "match_pulse", match_pulse, 1);
        chk("R6", "oc toggle", oc_bit, 1);
        settle();
        chk("R4", "match_pulse one cycle", match_pulse, 0);

        // R5 clear, then clear colliding with a match
        @(negedge clk); flag_clr = 1;
        settle();
        chk("R5", "flag cleared", match_flag, 0);
        @(negedge clk); flag_clr = 1; tick = 1;
        settle();
        chk("R5", "set wins over clear", match_flag, 1);
        chk("R6", "oc toggled back", oc_bit, 0);

        // R6 set, clear, hold
        @(negedge clk); act_sel = 2'd3; tick = 1;
        settle();
        chk("R6", "oc set", oc_bit, 1);
        @(negedge clk); act_sel = 2'd2; tick = 1;
        settle();
        chk("R6", "oc clear", oc_bit, 0);
        @(negedge clk); act_sel = 2'd3; tick = 1;
        settle();
        @(negedge clk); act_sel = 2'd0; tick = 1;
        settle();
        chk("R6", "oc hold", oc_bit, 1);
        @(negedge clk); flag_clr = 1;
        settle();

        // R7 force in normal mode
        @(negedge clk); act_sel = 2'd2; force_cmp = 1;
        settle();
        chk("R7", "force clear oc", oc_bit, 0);
        chk("R7", "force no flag", match_flag, 0);
        chk("R7", "force no pulse", match_pulse, 0);
        @(negedge clk); act_sel = 2'd3; force_cmp = 1;
        settle();
        chk("R7", "force set oc", oc_bit, 1);
        chk("R7", "force no flag", match_flag, 0);

        // R9 counter write blocks the next tick across idle cycles
        @(negedge clk); cnt_wr = 1;
        settle();
        repeat (5) settle();
        @(negedge clk); tick = 1;
        settle();
        chk("R9", "blocked match flag", match_flag, 0);
        chk("R9", "blocked match pulse", match_pulse, 0);
        @(negedge clk); tick = 1;
        settle();
        chk("R9", "next tick matches", match_flag, 1);
        @(negedge clk); flag_clr = 1;
        settle();

        // R10 pin selection, same-cycle
        @(negedge clk); act_sel = 2'd0; port_latch = 1; #1;
        chk("R10", "pin from latch", pin_out, 1);
        @(negedge clk); port_latch = 0; #1;
        chk("R10", "pin from latch low", pin_out, 0);
        @(negedge clk); act_sel = 2'd2; #1;
        chk("R10", "pin from oc", pin_out, 1);

        // R11 oc survives a mode change
        @(negedge clk); wave_mode = 2'd2; count = 8'h10;
        settle();
        chk("R11", "oc after mode change", oc_bit, 1);

        // R3 PWM updated at top
        @(negedge clk); cmp_wr = 1; cmp_wdata = 8'h80;
        settle();
        chk("R3", "buffered, not active", cmp_active, 8'h40);
        @(negedge clk); at_bottom = 1; tick = 1;
        settle();
        chk("R3", "no load at bottom", cmp_active, 8'h40);
        @(negedge clk); at_bottom = 0; at_top = 1; tick = 1;
        settle();
        chk("R3", "load at top", cmp_active, 8'h80);

        // R3 PWM updated at bottom
        @(negedge clk); at_top = 0; wave_mode = 2'd3; cmp_wr = 1; cmp_wdata = 8'h22;
        settle();
        chk("R3", "buffered bottom mode", cmp_active, 8'h80);
        @(negedge clk); at_top = 1; tick = 1;
        settle();
        chk("R3", "no load at top", cmp_active, 8'h80);
        @(negedge clk); at_top = 0; at_bottom = 1; tick = 1;
        settle();
        chk("R3", "load at bottom", cmp_active, 8'h22);
        @(negedge clk); at_bottom = 0;

        // R8 force ignored in PWM
        @(negedge clk); act_sel = 2'd2; force_cmp = 1;
        settle();
        chk("R8", "force ignored", oc_bit, 1);

        // R2 direct write in clear-on-match mode
        @(negedge clk); wave_mode = 2'd1; cmp_wr = 1; cmp_wdata = 8'h33;
        settle();
        chk("R2", "cmp_active clear-on-match", cmp_active, 8'h33);

        settle();
        finish_run();
    end

endmodule